// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Frame Controller

This block sits on the host side of a chain of dual-channel, 12-bit serial DACs that share a single chip-select and serial clock. The data output of each device feeds the data input of the next. A command gives one 12-bit code for each channel of every device. The controller then sends one frame of 24 bits per device in SPI mode 0: the clock idles low, the host changes data on the falling edge, and the devices sample it on the rising edge. The frame is ordered so that, once the last bit is sent, every device holds its own word. The devices then update in one of two ways. In the three-wire style, the load strobe is held low and the outputs change when chip-select rises. In the four-wire style, a separate low pulse on the load strobe follows chip-select.

While it shifts, the controller also captures the stream that comes back from the far end of the chain. That stream is the content the devices held before the frame, which is the previous frame's data. At the end of the frame the controller compares it with the previously written frame and raises a mismatch flag if any bit differs. Every serial timing minimum is a parameter counted in system clocks:
- the high and low phases of the serial clock,
- an extra low-phase wait that covers a slow open-drain return line,
- chip-select setup and hold,
- the inter-frame gap,
- the delay and width of the load pulse.

Commands arrive on a valid/ready port. `cmd_ready` is low for the whole frame. A command held valid while the block is busy waits, and is taken in the first cycle after `done`. The codes and mode are sampled only in the accept cycle.

Top module: `dac_chain_ctrl`

## Requirements
- R1: After reset, the block drives `cs_n`=1, `sclk`=0, `ldac_n`=1, `busy`=0, `cmd_ready`=1, `done`=0 and `mismatch`=0.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` always equals the inverse of `busy`. `busy` is high from the cycle after acceptance until `done`. `done` pulses for exactly one cycle, and `busy` is already low in that cycle.
- R3: A frame has exactly N_DEV*24 rising edges of `sclk`. `cmd_codes` bit 47 is sent first, and the vector is shifted MSB first. Device d (0 = nearest the controller) takes `cmd_codes[d*24+23:d*24]`. Its channel-B code is in the upper 12 bits of that slice and its channel-A code in the lower 12 bits. After the update, each device holds exactly its own slice.
- R4: `sclk` is low whenever `cs_n` is high. `mosi` does not change while `sclk` stays high. Each high phase lasts at least HALF_CYC cycles. Each low phase between two rising edges lasts at least HALF_CYC+EXTRA_CYC cycles.
- R5: The first rising edge of `sclk` comes no sooner than SETUP_CYC+HALF_CYC+EXTRA_CYC cycles after `cs_n` falls, and every rising edge occurs with `cs_n` low.
- R6: `cs_n` rises no sooner than HALF_CYC+HOLD_CYC cycles after the last rising edge of `sclk`.
- R7: Between two frames, `cs_n` stays high for at least GAP_CYC+1 cycles.
- R8: Three-wire mode is selected with `cmd_four_wire`=0. In this mode `ldac_n` is low from the cycle after acceptance onward, so the devices take the new words when `cs_n` rises.
- R9: Four-wire mode is selected with `cmd_four_wire`=1. In this mode `ldac_n` is high except for one low pulse of exactly LDW_CYC cycles. That pulse starts at least LDWAIT_CYC cycles after `cs_n` rises, and the device outputs do not change before it starts.
- R10: `miso` is sampled at each rising edge of `sclk`. In the `done` cycle, `mismatch` is 1 only if an earlier frame has been sent since reset and the captured N_DEV*24 bits differ from that frame's codes. The first frame after reset always gives 0.
- R11: `mismatch` is cleared when a command is accepted and stays 0 while `busy` is high. After `done` it keeps its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (block idle) |
| cmd_codes | input | N_DEV*24 | Channel codes, device d in bits d*24+23..d*24, B above A |
| cmd_four_wire | input | 1 | 1: load pulse update, 0: update on chip-select rise |
| cs_n | output | 1 | Chain chip-select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the nearest device |
| ldac_n | output | 1 | Load strobe, active low |
| miso | input | 1 | Serial data returning from the far end of the chain |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mismatch | output | 1 | Read-back differed from the previous frame |

## Verification
The assertions rely on a few assumptions about the inputs. Reset is held for at least one clock edge. All timing parameters are at least 1. `cmd_codes` and `cmd_four_wire` only matter in the cycle a command is accepted. The devices return data that changes only away from the rising `sclk` edges at which the controller samples it.

The bench meets these assumptions in the following ways:
- It holds each command valid until acceptance, including back-to-back commands held across a busy frame.
- Its chain model shifts on `sclk` rises and updates its outputs from the cs/load strobe levels, so returning bits change only after the controller has sampled them.
- It forces a read-back mismatch by inverting the returned stream for one whole frame, so the stream never changes at a sampling edge.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_LDWAIT,
    ST_PULSE,
    ST_GAP
  } seq_state_t;

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // phase ends on the last of `limit` cycles
  assign hit = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int FRAME_BITS = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_data,
  input  logic                  tx_shift,
  input  logic                  rx_capture,
  input  logic                  miso,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rx_data
);
  logic [FRAME_BITS-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_data <= '0;
    end else begin
      if (load)          tx_q <= load_data;
      else if (tx_shift) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
      if (load)            rx_data <= '0;
      else if (rx_capture) rx_data <= {rx_data[FRAME_BITS-2:0], miso};
    end
  end

  assign mosi = tx_q[FRAME_BITS-1];
endmodule

// File: rtl/dac_readback_check.sv
module dac_readback_check #(
  parameter int FRAME_BITS = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  finish,
  input  logic [FRAME_BITS-1:0] rx_data,
  output logic                  mismatch
);
  logic [FRAME_BITS-1:0] cur_q, prev_q;
  logic                  has_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      prev_q     <= '0;
      has_prev_q <= 1'b0;
      mismatch   <= 1'b0;
    end else if (start) begin
      cur_q    <= frame_in;
      mismatch <= 1'b0;
    end else if (finish) begin
      mismatch   <= has_prev_q && (rx_data != prev_q);
      prev_q     <= cur_q;
      has_prev_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int N_DEV      = 2,
  parameter int CODE_W     = 12,
  parameter int HALF_CYC   = 2,
  parameter int EXTRA_CYC  = 1,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int GAP_CYC    = 3,
  parameter int LDWAIT_CYC = 2,
  parameter int LDW_CYC    = 2,
  parameter int CNT_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [N_DEV*2*CODE_W-1:0] cmd_codes,
  input  logic                      cmd_four_wire,
  output logic                      cs_n,
  output logic                      sclk,
  output logic                      mosi,
  output logic                      ldac_n,
  input  logic                      miso,
  output logic                      busy,
  output logic                      done,
  output logic                      mismatch
);
  localparam int FRAME_BITS = N_DEV * 2 * CODE_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int LOW_CYC    = HALF_CYC + EXTRA_CYC;

  seq_state_t            st;
  logic [BIT_W-1:0]      bit_idx;
  logic                  four_q, ld_pulse;
  logic [CNT_W-1:0]      limit;
  logic                  hit, accept, advance;
  logic                  tx_shift, rx_capture, finish;
  logic [FRAME_BITS-1:0] rx_data;

  assign cmd_ready  = ~busy;
  assign accept     = cmd_valid && cmd_ready;
  assign advance    = accept || ((st != ST_IDLE) && hit);
  assign tx_shift   = (st == ST_HIGH) && hit;
  assign rx_capture = (st == ST_LOW) && hit;
  assign finish     = (st == ST_GAP) && hit;
  assign ldac_n     = four_q ? ~ld_pulse : 1'b0;

  always_comb begin
    case (st)
      ST_SETUP:  limit = CNT_W'(SETUP_CYC);
      ST_LOW:    limit = CNT_W'(LOW_CYC);
      ST_HIGH:   limit = CNT_W'(HALF_CYC);
      ST_HOLD:   limit = CNT_W'(HOLD_CYC);
      ST_LDWAIT: limit = CNT_W'(LDWAIT_CYC);
      ST_PULSE:  limit = CNT_W'(LDW_CYC);
      ST_GAP:    limit = CNT_W'(GAP_CYC);
      default:   limit = CNT_W'(1);
    endcase
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(advance), .limit(limit), .hit(hit)
  );

  dac_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(cmd_codes),
    .tx_shift(tx_shift), .rx_capture(rx_capture), .miso(miso),
    .mosi(mosi), .rx_data(rx_data)
  );

  dac_readback_check #(.FRAME_BITS(FRAME_BITS)) u_rbk (
    .clk(clk), .rst_n(rst_n), .start(accept), .frame_in(cmd_codes),
    .finish(finish), .rx_data(rx_data), .mismatch(mismatch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      four_q   <= 1'b1;
      ld_pulse <= 1'b0;
      bit_idx  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          cs_n    <= 1'b0;
          busy    <= 1'b1;
          four_q  <= cmd_four_wire;
          bit_idx <= '0;
          st      <= ST_SETUP;
        end
        ST_SETUP: if (hit) st <= ST_LOW;
        ST_LOW: if (hit) begin
          sclk <= 1'b1;
          st   <= ST_HIGH;
        end
        ST_HIGH: if (hit) begin
          sclk <= 1'b0;
          if (bit_idx == BIT_W'(FRAME_BITS - 1)) st <= ST_HOLD;
          else begin
            bit_idx <= bit_idx + 1'b1;
            st      <= ST_LOW;
          end
        end
        ST_HOLD: if (hit) begin
          cs_n <= 1'b1;
          st   <= four_q ? ST_LDWAIT : ST_GAP;
        end
        ST_LDWAIT: if (hit) begin
          ld_pulse <= 1'b1;
          st       <= ST_PULSE;
        end
        ST_PULSE: if (hit) begin
          ld_pulse <= 1'b0;
          st       <= ST_GAP;
        end
        ST_GAP: if (hit) begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_chain_ctrl_chk.sv
module dac_chain_ctrl_chk #(
  parameter int GAP_CYC = 3,
  parameter int CNT_W   = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic mismatch
);
  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       hi_cnt <= '1;
    else if (!cs_n)                   hi_cnt <= '0;
    else if (hi_cnt != {CNT_W{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == !busy);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_rise_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= CNT_W'(GAP_CYC + 1)));

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mismatch);
endmodule

bind dac_chain_ctrl dac_chain_ctrl_chk #(.GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .busy(busy), .done(done), .mismatch(mismatch)
);

// File: tb/dac_chain_ctrl_tb.sv
module dac_chain_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME  = 48;
  localparam int HALF   = 2;
  localparam int EXTRA  = 1;
  localparam int SETUP  = 2;
  localparam int HOLD   = 2;
  localparam int GAP    = 3;
  localparam int LDWAIT = 2;
  localparam int LDW    = 2;

  typedef struct {
    logic [FRAME-1:0] codes;
    bit               four;
    bit               mm;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_four_wire = 1'b0;
  logic [FRAME-1:0] cmd_codes = '0;
  logic cmd_ready, cs_n, sclk, mosi, ldac_n, busy, done, mismatch, miso;

  int checks = 0, errors = 0;
  bit finished = 0, sent_any = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_ctrl #(
    .N_DEV(2), .CODE_W(12), .HALF_CYC(HALF), .EXTRA_CYC(EXTRA), .SETUP_CYC(SETUP),
    .HOLD_CYC(HOLD), .GAP_CYC(GAP), .LDWAIT_CYC(LDWAIT), .LDW_CYC(LDW), .CNT_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_codes(cmd_codes), .cmd_four_wire(cmd_four_wire), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .ldac_n(ldac_n), .miso(miso), .busy(busy), .done(done),
    .mismatch(mismatch)
  );

  // chain of two devices: one long shift register plus output latches
  logic [FRAME-1:0] chain = '0, latch = '0;
  bit inv_miso = 0;
  always @(posedge sclk) if (!cs_n) chain <= {chain[FRAME-2:0], mosi};
  always @(posedge clk) if (cs_n && !ldac_n) latch <= chain;
  assign miso = chain[FRAME-1] ^ inv_miso;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // timing observer, sampled on falling clock edges
  int rises, setup_meas, hold_meas, gap_meas, ld_delay, ld_w, ld_run;
  int min_hi, min_lo, hi_run, lo_run, since_csf, since_rise, since_csr, cs_hi_run;
  int bad_mosi;
  logic [FRAME-1:0] lat_csf, lat_ldf;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_ld = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    since_csf++; since_rise++; since_csr++;
    if (!cs_n && p_cs) begin
      gap_meas = cs_hi_run; since_csf = 0; rises = 0;
      min_hi = 1000; min_lo = 1000; bad_mosi = 0; lat_csf = latch;
    end
    cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
    if (sclk && !p_sclk) begin
      rises++;
      if (rises == 1) setup_meas = since_csf;
      else if (lo_run < min_lo) min_lo = lo_run;
      since_rise = 0; hi_run = 1;
    end else if (!sclk && p_sclk) begin
      if (hi_run < min_hi) min_hi = hi_run;
      lo_run = 1;
    end else if (sclk) hi_run++;
    else lo_run++;
    if (sclk && p_sclk && mosi != p_mosi) bad_mosi++;
    if (cs_n && !p_cs) begin hold_meas = since_rise; since_csr = 0; end
    if (!ldac_n && p_ld && cs_n) begin ld_delay = since_csr; ld_run = 1; lat_ldf = latch; end
    else if (!ldac_n) ld_run++;
    if (ldac_n && !p_ld) ld_w = ld_run;
    p_cs = cs_n; p_sclk = sclk; p_ld = ldac_n; p_mosi = mosi;
  end

  // monitor: compares each finished frame with the scoreboard
  int frame_no = 0;
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) chk(0, "R2", "done with no pending command", 1, 0);
        else begin
          it = q.pop_front();
          chk(latch == it.codes, "R3", "device latches", latch, it.codes);
          chk(rises == FRAME, "R3", "rising edges per frame", rises, FRAME);
          chk(mismatch == it.mm, "R10", "read-back flag", mismatch, it.mm);
          chk(min_hi >= HALF, "R4", "sclk high width", min_hi, HALF);
          chk(min_lo >= HALF + EXTRA, "R4", "sclk low width", min_lo, HALF + EXTRA);
          chk(bad_mosi == 0, "R4", "mosi change while sclk high", bad_mosi, 0);
          chk(setup_meas >= SETUP + HALF + EXTRA, "R5", "cs fall to first rise",
              setup_meas, SETUP + HALF + EXTRA);
          chk(hold_meas >= HALF + HOLD, "R6", "last rise to cs rise", hold_meas, HALF + HOLD);
          if (frame_no > 0) chk(gap_meas >= GAP + 1, "R7", "cs high gap", gap_meas, GAP + 1);
          if (it.four) begin
            chk(lat_ldf == lat_csf, "R9", "latch before load pulse", lat_ldf, lat_csf);
            chk(ld_delay >= LDWAIT, "R9", "cs rise to load fall", ld_delay, LDWAIT);
            chk(ld_w == LDW, "R9", "load pulse width", ld_w, LDW);
          end else begin
            chk(ldac_n == 1'b0, "R8", "load strobe held low", ldac_n, 0);
          end
          frame_no++;
        end
      end
    end
  end

  task automatic send(input logic [FRAME-1:0] codes, input bit four, input bit inv);
    item_t it;
    @(negedge clk);
    cmd_codes = codes; cmd_four_wire = four; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    inv_miso = inv;
    it.codes = codes; it.four = four; it.mm = sent_any && inv;
    sent_any = 1;
    q.push_back(it);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R2", "busy after accept", {busy, cmd_ready}, 2'b10);
    chk(mismatch == 1'b0, "R11", "flag cleared on accept", mismatch, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && ldac_n == 1, "R1", "serial pins in reset",
        {cs_n, sclk, ldac_n}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && cmd_ready == 1 && done == 0 && mismatch == 0, "R1", "status after reset",
        {busy, cmd_ready, done, mismatch}, 4'b0100);
    send(48'hABC_123_456_789, 1'b0, 1'b0);   // first frame: no previous, flag 0 (R10)
    send(48'hFFF_FFF_000_000, 1'b1, 1'b0);   // four-wire update (R9)
    send(48'h000_FFF_FFF_000, 1'b1, 1'b1);   // corrupted return stream gives mismatch (R10)
    send(48'h555_AAA_AAA_555, 1'b0, 1'b0);   // flag cleared again (R11)
    send(48'h800_001_7FF_FFE, 1'b0, 1'b0);   // held valid while busy (R2)
    send(48'h123_456_789_ABC, 1'b1, 1'b0);
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(mismatch == 1'b0, "R11", "flag held after done", mismatch, 0);
    chk(latch[35:24] == 12'h456 && latch[47:36] == 12'h123, "R3", "far device B/A fields",
        latch[47:24], 24'h123456);
    chk(cs_n == 1 && sclk == 0, "R4", "idle serial pins", {cs_n, sclk}, 2'b10);
    finish_run();
  end
endmodule